// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a real address by walking a hashed page table held in memory. A request carries the effective address, the kind of access (read, write or instruction fetch) and whether the requester runs in user or supervisor mode. The top four address bits pick one of sixteen segment words, which are supplied as a flat configuration bus. A segment holds a 24-bit virtual segment id, two protection keys, a no-execute flag and a direct-store flag. A hash of the segment id and the page index selects a 64-byte group of eight 8-byte entries. The group is found through a table base and an offset mask that are also configuration inputs.

The walker scans the primary group and then the group at the complemented hash, one word at a time, through a single-outstanding memory read/write port. It checks the matching entry's protection against the access. On a granted access it sets the referenced bit, and the changed bit as well for a write, writing the second entry word back only when the value differs. It then answers with a status, the real address and the granted permissions.

Requests and responses use valid/ready handshakes. `req_ready` is high only while the walker is idle, so a request waits until the previous response has been taken. A response stays valid and unchanged until `rsp_ready` is seen. The memory port keeps a request valid and stable until `mem_req_ready`. The memory answers every accepted request, reads and writes alike, with one `mem_rsp_valid` pulse. It never applies back-pressure to responses.

Top module: `hpt_walker`

## Requirements
- R1: A request whose selected segment word (index ea[31:28]) has bit 31 set completes with status 4 (unsupported), real address 0 and permissions 0, and issues no memory access.
- R2: A fetch (access code 2) whose segment has bit 28 (no-execute) set completes with status 3, and issues no memory access.
- R3: The first probe reads word0 at base + ((H << 6) AND mask), where H = segment[23:0] XOR ea[27:12]. Each further probe reads the next 8-byte entry, up to eight entries in order. Word1 of an entry sits at word0's address + 4.
- R4: An entry matches when word0 bit 31 is 1, word0 bit 6 equals the search flag, and (word0 XOR ((vsid << 7) OR (ea[27:12] >> 10))) AND 0x7FFFFFBF is zero.
- R5: After eight primary misses, the walker searches the group at NOT H (32-bit complement, then shifted and masked) with flag 1. Missing there too gives status 1 (page fault) after exactly 16 reads.
- R6: The key is segment bit 29 in user mode and bit 30 in supervisor mode. pp is word1[1:0]. With key 0, pp 0, 1 and 2 give read and write, and pp 3 gives read only. With key 1, pp 0 gives nothing, pp 1 and 3 give read, and pp 2 gives read and write.
- R7: Execute is granted when segment bit 28 is clear. The access needs read (code 0), write (code 1) or execute (code 2). A missing right gives status 2 (protection fault) with permissions 0.
- R8: On a grant, word1 gets bit 8 set, plus bit 7 for writes. The new value is written back to word1's address only if it differs from the old one.
- R9: On success the status is 0 and the real address is {word1[31:12], ea[11:0]}.
- R10: The returned permissions are {X, W, R} in bits 2..0, with W cleared unless the access is a write.
- R11: Handshakes: a request is taken only when idle. A response is held stable until accepted. A memory request is held stable until `mem_req_ready`.
- R12: After reset `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request taken |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 user mode, 0 supervisor |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_status | output | 3 | 0 ok, 1 page fault, 2 protection fault, 3 no-execute fault, 4 unsupported |
| rsp_raddr | output | 32 | Real address (0 on fault) |
| rsp_perm | output | 3 | Granted rights {X,W,R} |
| seg_regs | input | 512 | Sixteen 32-bit segment words, word i at bits 32i+31..32i |
| cfg_base | input | 32 | Table base, 64-byte aligned |
| cfg_mask | input | 32 | Group offset mask |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Memory response (read data or write done) |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The in-line assertions watch on every cycle that the response and memory handshakes stay stable under back-pressure. They also check that a write-back always carries the referenced bit and targets a word1 address. They cover the response permissions (write implies read, no write on non-write accesses, nothing on faults) and the early exits for direct-store and no-execute segments. The probe order, the switch to the secondary group, the match rule with its decoys, the protection table across keys, modes and pp codes, and the conditional write-back can only be shown by the bench scenarios. These scenarios place entries at known slots and count the memory reads and writes.

// File: rtl/hptw_pkg.sv
package hptw_pkg;
  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    ST_OK          = 3'd0,
    ST_PAGE_FAULT  = 3'd1,
    ST_PROT_FAULT  = 3'd2,
    ST_NOEXEC      = 3'd3,
    ST_UNSUPPORTED = 3'd4
  } status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_W0_REQ, S_W0_WAIT, S_W1_REQ, S_W1_WAIT, S_WB_REQ, S_WB_WAIT, S_RESP
  } state_e;
endpackage

// File: rtl/hptw_hash.sv
module hptw_hash #(
  parameter int AW          = 32,
  parameter int VSID_W      = 24,
  parameter int PIDX_W      = 16,
  parameter int SLOT_W      = 3,
  parameter int GRP_SHIFT   = 6,
  parameter int ENTRY_SHIFT = 3,
  parameter int API_W       = 6
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] pidx,
  input  logic              secondary,
  input  logic [SLOT_W-1:0] slot,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     mask,
  output logic [AW-1:0]     w0_addr,
  output logic [31:0]       cmp_word
);
  localparam int API_SHIFT  = PIDX_W - API_W;
  localparam int VSID_SHIFT = API_W + 1;

  logic [AW-1:0] hash_full;
  logic [AW-1:0] hash_sel;
  logic [AW-1:0] grp_off;

  always_comb begin
    hash_full = AW'(vsid ^ VSID_W'(pidx));
    hash_sel  = secondary ? ~hash_full : hash_full;
    grp_off   = (hash_sel << GRP_SHIFT) & mask;
    w0_addr   = base + grp_off + (AW'(slot) << ENTRY_SHIFT);
    cmp_word  = (32'(vsid) << VSID_SHIFT) | 32'(pidx >> API_SHIFT);
  end
endmodule

// File: rtl/hptw_prot.sv
module hptw_prot
  import hptw_pkg::*;
(
  input  logic       key,
  input  logic [1:0] pp,
  input  logic       nx,
  input  acc_e       acc,
  output logic [2:0] perm_out,
  output logic       grant
);
  logic rd, wr;
  logic [2:0] full, need;

  always_comb begin
    if (!key) begin
      rd = 1'b1;
      wr = (pp != 2'd3);
    end else begin
      rd = (pp != 2'd0);
      wr = (pp == 2'd2);
    end
    full = '0;
    full[PERM_R] = rd;
    full[PERM_W] = wr;
    full[PERM_X] = !nx;
    need = '0;
    case (acc)
      ACC_WRITE: need[PERM_W] = 1'b1;
      ACC_FETCH: need[PERM_X] = 1'b1;
      default:   need[PERM_R] = 1'b1;
    endcase
    grant    = |(full & need);
    perm_out = full;
    if (acc != ACC_WRITE) perm_out[PERM_W] = 1'b0;
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hptw_pkg::*;
#(
  parameter int SEG_N       = 16,
  parameter int ENTRIES     = 8,
  parameter int ENTRY_BYTES = 8,
  parameter int PAGE_SHIFT  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [31:0]         req_ea,
  input  logic [1:0]          req_acc,
  input  logic                req_user,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [2:0]          rsp_status,
  output logic [31:0]         rsp_raddr,
  output logic [2:0]          rsp_perm,
  input  logic [SEG_N*32-1:0] seg_regs,
  input  logic [31:0]         cfg_base,
  input  logic [31:0]         cfg_mask,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_we,
  output logic [31:0]         mem_req_addr,
  output logic [31:0]         mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [31:0]         mem_rsp_rdata
);
  localparam int SEG_IDX_W  = $clog2(SEG_N);
  localparam int SLOT_W     = $clog2(ENTRIES);
  localparam int GRP_SHIFT  = $clog2(ENTRIES * ENTRY_BYTES);
  localparam int ENT_SHIFT  = $clog2(ENTRY_BYTES);
  localparam int PIDX_W     = 32 - SEG_IDX_W - PAGE_SHIFT;
  localparam int VSID_W     = 24;
  localparam int DS_BIT     = 31;
  localparam int KS_BIT     = 30;
  localparam int KP_BIT     = 29;
  localparam int NX_BIT     = 28;
  localparam int REF_BIT    = 8;
  localparam int CHG_BIT    = 7;
  localparam int FLAG_BIT   = 6;
  localparam logic [31:0] CMP_MASK = 32'h7FFF_FFBF;

  state_e             state;
  logic [31:0]        ea_q;
  acc_e               acc_q;
  logic               user_q;
  logic [31:0]        seg_q;
  logic               sec_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [31:0]        hit_addr_q;
  logic [31:0]        wb_q;
  status_e            st_q;
  logic [31:0]        raddr_q;
  logic [2:0]         perm_q;

  logic [31:0] seg_sel;
  logic [31:0] w0_addr;
  logic [31:0] cmp_word;
  logic        entry_hit;
  logic [2:0]  perm_new;
  logic        grant;
  logic        key;
  logic [31:0] new_w1;

  assign seg_sel = seg_regs[{req_ea[31 -: SEG_IDX_W], 5'b0} +: 32];

  hptw_hash #(
    .AW(32), .VSID_W(VSID_W), .PIDX_W(PIDX_W), .SLOT_W(SLOT_W),
    .GRP_SHIFT(GRP_SHIFT), .ENTRY_SHIFT(ENT_SHIFT), .API_W(6)
  ) u_hash (
    .vsid(seg_q[VSID_W-1:0]),
    .pidx(ea_q[PAGE_SHIFT +: PIDX_W]),
    .secondary(sec_q),
    .slot(slot_q),
    .base(cfg_base),
    .mask(cfg_mask),
    .w0_addr(w0_addr),
    .cmp_word(cmp_word)
  );

  assign entry_hit = mem_rsp_rdata[31]
                   && (mem_rsp_rdata[FLAG_BIT] == sec_q)
                   && (((mem_rsp_rdata ^ cmp_word) & CMP_MASK) == 32'd0);

  assign key = user_q ? seg_q[KP_BIT] : seg_q[KS_BIT];

  hptw_prot u_prot (
    .key(key),
    .pp(mem_rsp_rdata[1:0]),
    .nx(seg_q[NX_BIT]),
    .acc(acc_q),
    .perm_out(perm_new),
    .grant(grant)
  );

  always_comb begin
    new_w1 = mem_rsp_rdata;
    new_w1[REF_BIT] = 1'b1;
    if (acc_q == ACC_WRITE) new_w1[CHG_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ea_q       <= '0;
      acc_q      <= ACC_READ;
      user_q     <= 1'b0;
      seg_q      <= '0;
      sec_q      <= 1'b0;
      slot_q     <= '0;
      hit_addr_q <= '0;
      wb_q       <= '0;
      st_q       <= ST_OK;
      raddr_q    <= '0;
      perm_q     <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          ea_q    <= req_ea;
          acc_q   <= acc_e'(req_acc);
          user_q  <= req_user;
          seg_q   <= seg_sel;
          sec_q   <= 1'b0;
          slot_q  <= '0;
          raddr_q <= '0;
          perm_q  <= '0;
          if (seg_sel[DS_BIT]) begin
            st_q  <= ST_UNSUPPORTED;
            state <= S_RESP;
          end else if (acc_e'(req_acc) == ACC_FETCH && seg_sel[NX_BIT]) begin
            st_q  <= ST_NOEXEC;
            state <= S_RESP;
          end else begin
            state <= S_W0_REQ;
          end
        end
        S_W0_REQ: if (mem_req_ready) state <= S_W0_WAIT;
        S_W0_WAIT: if (mem_rsp_valid) begin
          if (entry_hit) begin
            hit_addr_q <= w0_addr;
            state      <= S_W1_REQ;
          end else if (slot_q == SLOT_W'(ENTRIES - 1)) begin
            if (sec_q) begin
              st_q  <= ST_PAGE_FAULT;
              state <= S_RESP;
            end else begin
              sec_q  <= 1'b1;
              slot_q <= '0;
              state  <= S_W0_REQ;
            end
          end else begin
            slot_q <= slot_q + 1'b1;
            state  <= S_W0_REQ;
          end
        end
        S_W1_REQ: if (mem_req_ready) state <= S_W1_WAIT;
        S_W1_WAIT: if (mem_rsp_valid) begin
          if (!grant) begin
            st_q  <= ST_PROT_FAULT;
            state <= S_RESP;
          end else begin
            st_q    <= ST_OK;
            raddr_q <= {mem_rsp_rdata[31:PAGE_SHIFT], ea_q[PAGE_SHIFT-1:0]};
            perm_q  <= perm_new;
            wb_q    <= new_w1;
            state   <= (new_w1 != mem_rsp_rdata) ? S_WB_REQ : S_RESP;
          end
        end
        S_WB_REQ:  if (mem_req_ready) state <= S_WB_WAIT;
        S_WB_WAIT: if (mem_rsp_valid) state <= S_RESP;
        S_RESP:    if (rsp_ready) state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign rsp_valid     = (state == S_RESP);
  assign rsp_status    = st_q;
  assign rsp_raddr     = raddr_q;
  assign rsp_perm      = perm_q;
  assign mem_req_valid = (state == S_W0_REQ) || (state == S_W1_REQ) || (state == S_WB_REQ);
  assign mem_req_we    = (state == S_WB_REQ);
  assign mem_req_addr  = (state == S_W0_REQ) ? w0_addr : (hit_addr_q + 32'd4);
  assign mem_req_wdata = wb_q;

  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R11
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status) && $stable(rsp_raddr) && $stable(rsp_perm)); // R11
  AST_DIRECT_STORE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && seg_sel[DS_BIT] |=> rsp_valid && rsp_status == ST_UNSUPPORTED && !mem_req_valid); // R1
  AST_NOEXEC_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !seg_sel[DS_BIT] && req_acc == 2'd2 && seg_sel[NX_BIT]
    |=> rsp_valid && rsp_status == ST_NOEXEC); // R2
  AST_WB_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[REF_BIT] && mem_req_addr[2]); // R8
  AST_OK_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status == ST_OK |-> rsp_raddr[PAGE_SHIFT-1:0] == ea_q[PAGE_SHIFT-1:0]); // R9
  AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_perm[PERM_W] |-> rsp_perm[PERM_R]); // R6
  AST_NONWRITE_NO_W: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && acc_q != ACC_WRITE |-> !rsp_perm[PERM_W]); // R10
  AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status != ST_OK |-> rsp_perm == 3'd0); // R7
endmodule

// File: tb/test_hpt_walker.sv
module test_hpt_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_user = 1'b0;
  logic [31:0] req_ea = '0;
  logic [1:0] req_acc = '0;
  logic rsp_valid, rsp_ready = 1'b0;
  logic [2:0] rsp_status, rsp_perm;
  logic [31:0] rsp_raddr;
  logic [511:0] seg_regs = '0;
  logic [31:0] cfg_base = 32'h0, cfg_mask = 32'h0000_3FC0;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  logic [31:0] mem [0:4095];
  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0, cyc = 0;
  logic [31:0] first_rd;
  logic hs_pend = 1'b0, hs_we;
  logic [31:0] hs_addr, hs_wdata;
  logic [2:0] got_st, got_pm;
  logic [31:0] got_ra;

  always #2.5 clk = ~clk;

  hpt_walker i_hpt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_acc(req_acc), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_raddr(rsp_raddr), .rsp_perm(rsp_perm),
    .seg_regs(seg_regs), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  initial forever begin
    @(negedge clk);
    cyc++;
    mem_rsp_valid = 1'b0;
    if (hs_pend) begin
      if (hs_we) begin
        mem[hs_addr[13:2]] = hs_wdata;
        wr_cnt++;
      end else begin
        mem_rsp_rdata = mem[hs_addr[13:2]];
        if (rd_cnt == 0) first_rd = hs_addr;
        rd_cnt++;
      end
      mem_rsp_valid = 1'b1;
      hs_pend = 1'b0;
    end
    mem_req_ready = (cyc % 3 != 1);
    if (mem_req_valid && mem_req_ready) begin
      hs_pend = 1'b1; hs_we = mem_req_we; hs_addr = mem_req_addr; hs_wdata = mem_req_wdata;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_perm(input logic key, input logic [1:0] pp, input logic nx);
    logic r, w;
    if (!key) begin r = 1'b1; w = (pp != 2'd3); end
    else begin r = (pp != 2'd0); w = (pp == 2'd2); end
    return {!nx, w, r};
  endfunction

  task automatic translate(input logic [31:0] ea, input logic [1:0] acc, input logic user, input bit stall);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; first_rd = 32'hFFFF_FFFF;
    req_ea = ea; req_acc = acc; req_user = user; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    if (stall) @(negedge clk);
    got_st = rsp_status; got_ra = rsp_raddr; got_pm = rsp_perm;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R12 req_ready after reset", {31'd0, req_ready}, 32'd1);
    check("R12 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    check("R12 mem_req_valid after reset", {31'd0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;

    for (int t = 0; t < 48; t++) begin
      logic [1:0] pp, acc;
      logic user, keyb, nx, sec, rcpre, key, need;
      logic [23:0] vsid;
      logic [15:0] pidx;
      logic [11:0] off;
      logic [3:0] si;
      logic [31:0] h, pg, sg, grp, w0, w1, nw1, seg;
      logic [2:0] full, pexp;
      int slot, exp_rd;
      pp = 2'(t % 4); acc = 2'((t / 4) % 3); user = ((t / 12) % 2) == 1;
      keyb = ((t / 24) % 2) == 1; nx = (t % 5 == 0); sec = (t % 3 == 2);
      rcpre = ((t / 2) % 2) == 1; slot = t % 8; si = 4'(t % 16);
      vsid = 24'h0A0000 + 24'(t * 4951); pidx = 16'(t * 291 + 7); off = 12'(t * 53);
      seg = {1'b0, user ? !keyb : keyb, user ? keyb : !keyb, nx, 4'h0, vsid};
      seg_regs[si * 32 +: 32] = seg;
      key = keyb;
      h = {8'h0, vsid ^ {8'h0, pidx}};
      pg = (h << 6) & cfg_mask;
      sg = ((~h) << 6) & cfg_mask;
      for (int k = 0; k < 16; k++) begin mem[pg[13:2] + k] = '0; mem[sg[13:2] + k] = '0; end
      grp = sec ? sg : pg;
      w0 = {1'b1, vsid, sec, pidx[15:10]};
      w1 = {20'h80000 + 20'(t * 97), 12'h0} | (rcpre ? 32'h180 : 32'h0) | {30'd0, pp};
      mem[(grp + 32'(slot * 8)) >> 2] = w0;
      mem[((grp + 32'(slot * 8)) >> 2) + 1] = w1;
      if (slot > 0) mem[(grp + 32'((slot - 1) * 8)) >> 2] = {1'b1, vsid, !sec, pidx[15:10]};
      if (slot > 1) mem[(grp + 32'((slot - 2) * 8)) >> 2] = {1'b1, vsid ^ 24'h1, sec, pidx[15:10]};
      if (sec) mem[(pg + 32'd24) >> 2] = {1'b1, vsid, 1'b1, pidx[15:10]};
      translate({si, pidx, off}, acc, user, (t % 2) == 1);
      if (acc == 2'd2 && nx) begin
        check("R2 noexec status", {29'd0, got_st}, 32'd3);
        check("R2 no memory read", rd_cnt, 0);
      end else begin
        exp_rd = (sec ? 8 : 0) + slot + 2;
        check("R5 read count (R3 slot order)", rd_cnt, exp_rd);
        check("R3 first probe address", first_rd, pg);
        full = exp_perm(key, pp, nx);
        need = (acc == 2'd0) ? full[0] : (acc == 2'd1) ? full[1] : full[2];
        if (!need) begin
          check("R7 protection fault status", {29'd0, got_st}, 32'd2);
          check("R7 no write-back on fault", wr_cnt, 0);
          check("R7 fault perm zero", {29'd0, got_pm}, 32'd0);
        end else begin
          pexp = full;
          if (acc != 2'd1) pexp[1] = 1'b0;
          nw1 = w1 | 32'h100 | ((acc == 2'd1) ? 32'h80 : 32'h0);
          check("R9 ok status", {29'd0, got_st}, 32'd0);
          check("R9 real address", got_ra, {w1[31:12], off});
          check("R6 R10 permissions", {29'd0, got_pm}, {29'd0, pexp});
          check("R8 write-back count", wr_cnt, (nw1 != w1) ? 1 : 0);
          check("R8 word1 in memory", mem[((grp + 32'(slot * 8)) >> 2) + 1], nw1);
        end
      end
    end

    for (int t = 0; t < 3; t++) begin
      logic [31:0] h, pg, sg;
      logic [23:0] vsid;
      vsid = 24'h123456 + 24'(t * 77);
      seg_regs[5 * 32 +: 32] = {8'h00, vsid};
      h = {8'h0, vsid ^ 24'h00ABCD};
      pg = (h << 6) & cfg_mask;
      sg = ((~h) << 6) & cfg_mask;
      for (int k = 0; k < 16; k++) begin mem[pg[13:2] + k] = '0; mem[sg[13:2] + k] = '0; end
      mem[pg[13:2]] = {1'b0, vsid, 1'b0, 6'h2A};
      mem[sg[13:2] + 2] = {1'b1, vsid, 1'b0, 6'h2A};
      translate({4'h5, 16'hABCD, 12'h123}, 2'(t), 1'b0, 1'b0);
      check("R5 page fault status", {29'd0, got_st}, 32'd1);
      check("R5 sixteen probes", rd_cnt, 16);
      check("R4 invalid/flag entries ignored, perm zero", {29'd0, got_pm}, 32'd0);
    end

    for (int t = 0; t < 3; t++) begin
      seg_regs[9 * 32 +: 32] = 32'h8000_0000 | 32'(t * 1234);
      translate({4'h9, 28'h0ABC123}, 2'(t), t[0], t == 1);
      check("R1 unsupported status", {29'd0, got_st}, 32'd4);
      check("R1 no memory access", rd_cnt + wr_cnt, 0);
      check("R1 raddr zero", got_ra, 32'd0);
    end

    summary();
    $finish;
  end
endmodule